// File: doc/BRIEF.md
# Bootstrapped Gain Calibration Sequencer

This block runs the adaptive estimation of two model coefficients for one stage of a pipelined converter. The first is a constant gain estimate (`ge`). The second is a gain-variation coefficient (`be`). The block works out which test condition the analog side must apply next and publishes it as a request. The request is either a level near one of the two comparator thresholds with a forced comparator decision, or one of the two large test levels of opposite sign. The block then waits for the digitised result and folds each completed group of results into a fixed-point update with a power-of-two step size.

The two loops feed each other. At the end of every calibration cycle the block re-measures the distance between the two large test levels and stores it. The next cycle's variation updates compare against that stored distance, so a fresh gain estimate sharpens the variation estimate and the reverse. The variation estimate can settle at a false operating point when it passes through zero. If an update flips its sign, the block lowers its starting gain estimate and begins the schedule again. A start strobe launches a run. A busy flag, a one-cycle done pulse and a sticky timeout flag report the run's progress.

Top module: `cal_gain_seq`

## Requirements
- R1: After reset, and again on the edge that accepts `start_i` while idle, `ge_o` equals GE_INIT and `be_o` is zero. While idle with no start, `busy_o`, `done_o` and `req_valid_o` are low, and `ge_o` and `be_o` do not change.
- R2: One gain update uses four measurements in a fixed order. `req_level_o` encodes 0 as the lower threshold level, 1 as the upper threshold level, 2 as the positive large level and 3 as the negative large level. `req_cmp_o`=1 forces the comparator high. The order is (0,1), (0,0), (1,1), (1,0).
- R3: With the four results a, b, c, d, the gain update is ge := ge − (((a−b)+(c−d)) >>> (MU_SHIFT+1)), using an arithmetic (flooring) shift. The sum of the two threshold differences is halved, which averages the two thresholds.
- R4: A distance measurement and a variation update each request level 2 and then level 3, with `req_cmp_o`=0, giving p and n. A distance measurement stores p−n. A variation update is be := be + ((p−n−stored) >>> MU_SHIFT).
- R5: A run consists of a first cycle and then N_CYC later cycles. The first cycle is FIRST_G gain updates followed by one distance measurement, with no variation update. Each later cycle is G_UPD gain updates, then B_UPD variation updates, then one distance measurement.
- R6: `ge_o` and `be_o` saturate at the signed COEF_W limits instead of wrapping.
- R7: A variation update that would take a nonzero `be` to the opposite sign is not applied. Instead `be` becomes 0, the start value drops by GE_BACKOFF (with saturation), `ge` is set to that new start value, and the schedule begins again at a first cycle.
- R8: `req_valid_o` is high exactly while busy, and its fields hold until a measurement is taken on an edge with `meas_valid_i` high. `meas_valid_i` has no effect while no request is pending.
- R9: `done_o` pulses for one cycle on the edge after the last measurement is taken, and `busy_o` falls at the same time. `start_i` while busy has no effect.
- R10: A request left unanswered for TMO_CYC clock edges aborts the run. `busy_o` falls and `done_o` stays low. `timeout_o` is set and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calibration run when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a complete run |
| timeout_o | output | 1 | Last run aborted for lack of a measurement |
| req_valid_o | output | 1 | A measurement is requested |
| req_level_o | output | 2 | Requested test level (0 lower thr, 1 upper thr, 2 positive, 3 negative) |
| req_cmp_o | output | 1 | Forced comparator decision for threshold levels |
| meas_valid_i | input | 1 | Measurement strobe |
| meas_i | input | MEAS_W | Signed digitised result |
| ge_o | output | COEF_W | Signed constant-gain estimate |
| be_o | output | COEF_W | Signed gain-variation estimate |

## Verification
The bench builds the block with MEAS_W=12, COEF_W=14, MU_SHIFT=2, FIRST_G=2, G_UPD=3, B_UPD=2, N_CYC=2, GE_INIT=1000, GE_BACKOFF=64 and TMO_CYC=16. A full run is then only 46 measurements. Because COEF_W is narrow, a few large threshold differences drive the gain estimate into its upper limit. The small shift makes single-step flooring of negative differences visible. Because cycles are short, a variation sign flip and the restart that follows fit into one run. The short timeout lets the bench watch an abort at an exact edge count.

// File: rtl/cal_gain_pkg.sv
package cal_gain_pkg;
  typedef enum logic [1:0] {
    LVL_THR_LO = 2'd0,
    LVL_THR_HI = 2'd1,
    LVL_POS    = 2'd2,
    LVL_NEG    = 2'd3
  } cal_lvl_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GE   = 2'd1,
    PH_BE   = 2'd2,
    PH_DIST = 2'd3
  } cal_phase_e;
endpackage

// File: rtl/cal_gain_sched.sv
module cal_gain_sched
  import cal_gain_pkg::*;
#(
  parameter int FIRST_G = 4,
  parameter int G_UPD   = 1024,
  parameter int B_UPD   = 256,
  parameter int N_CYC   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       accept_i,
  input  logic       restart_i,
  input  logic       abort_i,
  output cal_phase_e phase_o,
  output logic [1:0] sub_o,
  output logic       busy_o,
  output logic       done_o,
  output cal_lvl_e   lvl_o,
  output logic       cmp_o
);
  localparam int MAX_G   = (FIRST_G > G_UPD) ? FIRST_G : G_UPD;
  localparam int MAX_UPD = (MAX_G > B_UPD) ? MAX_G : B_UPD;
  localparam int UW      = $clog2(MAX_UPD + 1);
  localparam int CW      = $clog2(N_CYC + 1) + 1;
  localparam logic [UW-1:0] FIRST_LAST = UW'(FIRST_G - 1);
  localparam logic [UW-1:0] G_LAST     = UW'(G_UPD - 1);
  localparam logic [UW-1:0] B_LAST     = UW'(B_UPD - 1);
  localparam logic [CW-1:0] CYC_LAST   = CW'(N_CYC);

  cal_phase_e      phase_q;
  logic [1:0]      sub_q;
  logic [UW-1:0]   upd_q, upd_last;
  logic [CW-1:0]   cyc_q;
  logic            first_q, done_q, grp_last;

  assign grp_last = (phase_q == PH_GE) ? (sub_q == 2'd3) : (sub_q == 2'd1);
  assign upd_last = first_q ? FIRST_LAST : ((phase_q == PH_GE) ? G_LAST : B_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sub_q   <= 2'd0;
      upd_q   <= '0;
      cyc_q   <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= PH_GE;
          sub_q   <= 2'd0;
          upd_q   <= '0;
          cyc_q   <= '0;
          first_q <= 1'b1;
        end
      end else if (abort_i) begin
        phase_q <= PH_IDLE;
      end else if (accept_i) begin
        sub_q <= grp_last ? 2'd0 : sub_q + 2'd1;
        if (grp_last) begin
          case (phase_q)
            PH_GE: begin
              if (upd_q == upd_last) begin
                upd_q   <= '0;
                phase_q <= first_q ? PH_DIST : PH_BE;
              end else begin
                upd_q <= upd_q + UW'(1);
              end
            end
            PH_BE: begin
              if (restart_i) begin
                phase_q <= PH_GE;
                upd_q   <= '0;
                cyc_q   <= '0;
                first_q <= 1'b1;
              end else if (upd_q == upd_last) begin
                upd_q   <= '0;
                phase_q <= PH_DIST;
              end else begin
                upd_q <= upd_q + UW'(1);
              end
            end
            PH_DIST: begin
              if (cyc_q == CYC_LAST) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                cyc_q   <= cyc_q + CW'(1);
                first_q <= 1'b0;
                phase_q <= PH_GE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    lvl_o = LVL_POS;
    cmp_o = 1'b0;
    case (phase_q)
      PH_GE: begin
        lvl_o = sub_q[1] ? LVL_THR_HI : LVL_THR_LO;
        cmp_o = ~sub_q[0];
      end
      PH_BE, PH_DIST: lvl_o = sub_q[0] ? LVL_NEG : LVL_POS;
      default: ;
    endcase
  end

  assign phase_o = phase_q;
  assign sub_o   = sub_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/cal_gain_dp.sv
module cal_gain_dp
  import cal_gain_pkg::*;
#(
  parameter int MEAS_W     = 16,
  parameter int COEF_W     = 20,
  parameter int MU_SHIFT   = 5,
  parameter int GE_INIT    = 16384,
  parameter int GE_BACKOFF = 1024
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     accept_i,
  input  cal_phase_e               phase_i,
  input  logic [1:0]               sub_i,
  input  logic signed [MEAS_W-1:0] meas_i,
  output logic signed [COEF_W-1:0] ge_o,
  output logic signed [COEF_W-1:0] be_o,
  output logic                     restart_o
);
  localparam int DW    = MEAS_W + 2;
  localparam int PW    = MEAS_W + 1;
  localparam int EXT_W = ((COEF_W > DW) ? COEF_W : DW) + 2;
  localparam logic signed [EXT_W-1:0] SAT_HI = {{(EXT_W-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SAT_LO = {{(EXT_W-COEF_W+1){1'b1}}, {(COEF_W-1){1'b0}}};
  localparam logic signed [COEF_W-1:0] INIT_V = COEF_W'(GE_INIT);

  function automatic logic signed [COEF_W-1:0] sat_f(input logic signed [EXT_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[COEF_W-1:0];
    else if (v < SAT_LO) return SAT_LO[COEF_W-1:0];
    else                 return v[COEF_W-1:0];
  endfunction

  logic signed [MEAS_W-1:0] m0_q, m1_q, m2_q;
  logic signed [PW-1:0]     bdist_q, pair;
  logic signed [DW-1:0]     g_sum, g_step, b_err, b_step;
  logic signed [COEF_W-1:0] ge_q, be_q, init_q, ge_cand, be_cand, init_cand;
  logic                     grp_end, be_pos, be_neg, flip;

  assign g_sum  = DW'(m0_q) - DW'(m1_q) + DW'(m2_q) - DW'(meas_i);
  assign g_step = g_sum >>> (MU_SHIFT + 1);
  assign pair   = PW'(m0_q) - PW'(meas_i);
  assign b_err  = DW'(pair) - DW'(bdist_q);
  assign b_step = b_err >>> MU_SHIFT;

  assign ge_cand   = sat_f(EXT_W'(ge_q) - EXT_W'(g_step));
  assign be_cand   = sat_f(EXT_W'(be_q) + EXT_W'(b_step));
  assign init_cand = sat_f(EXT_W'(init_q) - EXT_W'(GE_BACKOFF));

  assign grp_end = accept_i && ((phase_i == PH_GE) ? (sub_i == 2'd3) : (sub_i == 2'd1));
  assign be_pos  = !be_q[COEF_W-1] && (be_q != '0);
  assign be_neg  = be_q[COEF_W-1];
  // sign flip only from a nonzero value
  assign flip    = (be_pos && be_cand[COEF_W-1]) ||
                   (be_neg && !be_cand[COEF_W-1] && (be_cand != '0));
  assign restart_o = grp_end && (phase_i == PH_BE) && flip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ge_q    <= INIT_V;
      init_q  <= INIT_V;
      be_q    <= '0;
      m0_q    <= '0;
      m1_q    <= '0;
      m2_q    <= '0;
      bdist_q <= '0;
    end else if (load_i) begin
      ge_q   <= INIT_V;
      init_q <= INIT_V;
      be_q   <= '0;
    end else if (accept_i) begin
      case (sub_i)
        2'd0: m0_q <= meas_i;
        2'd1: m1_q <= meas_i;
        2'd2: m2_q <= meas_i;
        default: ;
      endcase
      if (grp_end) begin
        case (phase_i)
          PH_GE: ge_q <= ge_cand;
          PH_BE: begin
            if (flip) begin
              ge_q   <= init_cand;
              init_q <= init_cand;
              be_q   <= '0;
            end else begin
              be_q <= be_cand;
            end
          end
          PH_DIST: bdist_q <= pair;
          default: ;
        endcase
      end
    end
  end

  assign ge_o = ge_q;
  assign be_o = be_q;
endmodule

// File: rtl/cal_gain_wdog.sv
module cal_gain_wdog #(
  parameter int TMO_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wait_i,
  input  logic accept_i,
  output logic abort_o,
  output logic timeout_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(TMO_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic          tmo_q;

  assign abort_o = wait_i && !accept_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= (!wait_i || accept_i) ? '0 : cnt_q + TW'(1);
      if (clr_i)        tmo_q <= 1'b0;
      else if (abort_o) tmo_q <= 1'b1;
    end
  end

  assign timeout_o = tmo_q;
endmodule

// File: rtl/cal_gain_seq.sv
module cal_gain_seq
  import cal_gain_pkg::*;
#(
  parameter int MEAS_W     = 16,
  parameter int COEF_W     = 20,
  parameter int MU_SHIFT   = 5,
  parameter int FIRST_G    = 4,
  parameter int G_UPD      = 1024,
  parameter int B_UPD      = 256,
  parameter int N_CYC      = 8,
  parameter int GE_INIT    = 16384,
  parameter int GE_BACKOFF = 1024,
  parameter int TMO_CYC    = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              req_valid_o,
  output logic [1:0]        req_level_o,
  output logic              req_cmp_o,
  input  logic              meas_valid_i,
  input  logic [MEAS_W-1:0] meas_i,
  output logic [COEF_W-1:0] ge_o,
  output logic [COEF_W-1:0] be_o
);
  cal_phase_e phase;
  cal_lvl_e   lvl;
  logic [1:0] sub;
  logic       busy, accept, load, restart, abort;
  logic signed [COEF_W-1:0] ge_s, be_s;

  assign accept = busy && meas_valid_i;
  assign load   = start_i && !busy;

  cal_gain_sched #(
    .FIRST_G(FIRST_G), .G_UPD(G_UPD), .B_UPD(B_UPD), .N_CYC(N_CYC)
  ) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .accept_i(accept),
    .restart_i(restart), .abort_i(abort), .phase_o(phase), .sub_o(sub),
    .busy_o(busy), .done_o(done_o), .lvl_o(lvl), .cmp_o(req_cmp_o)
  );

  cal_gain_dp #(
    .MEAS_W(MEAS_W), .COEF_W(COEF_W), .MU_SHIFT(MU_SHIFT),
    .GE_INIT(GE_INIT), .GE_BACKOFF(GE_BACKOFF)
  ) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .accept_i(accept),
    .phase_i(phase), .sub_i(sub), .meas_i(meas_i),
    .ge_o(ge_s), .be_o(be_s), .restart_o(restart)
  );

  cal_gain_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .wait_i(busy),
    .accept_i(accept), .abort_o(abort), .timeout_o(timeout_o)
  );

  assign busy_o      = busy;
  assign req_valid_o = busy;
  assign req_level_o = lvl;
  assign ge_o        = ge_s;
  assign be_o        = be_s;
endmodule

// File: rtl/cal_gain_seq_chk.sv
module cal_gain_seq_chk #(
  parameter int MEAS_W = 16,
  parameter int COEF_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              req_valid_o,
  input logic [1:0]        req_level_o,
  input logic              req_cmp_o,
  input logic              meas_valid_i,
  input logic [COEF_W-1:0] ge_o,
  input logic [COEF_W-1:0] be_o
);
  // R8
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !meas_valid_i |=>
      (req_valid_o && $stable(req_level_o) && $stable(req_cmp_o)) || timeout_o);

  // R8
  idle_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(ge_o) && $stable(be_o));

  // R10
  tmo_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !busy_o && !done_o);

  // R10
  tmo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !(start_i && !busy_o) |=> timeout_o);
endmodule

bind cal_gain_seq cal_gain_seq_chk #(.MEAS_W(MEAS_W), .COEF_W(COEF_W)) u_chk (.*);

// File: tb/tb_cal_gain_seq.sv
`timescale 1ns/1ps
module tb_cal_gain_seq;
  localparam int MEAS_W = 12, COEF_W = 14, MU_SHIFT = 2;
  localparam int FIRST_G = 2, G_UPD = 3, B_UPD = 2, N_CYC = 2;
  localparam int GE_INIT = 1000, GE_BACKOFF = 64, TMO_CYC = 16;
  localparam int CMAX = (1 << (COEF_W-1)) - 1;
  localparam int CMIN = -(1 << (COEF_W-1));

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, meas_valid_i = 1'b0;
  logic [MEAS_W-1:0] meas_i = '0;
  logic busy_o, done_o, timeout_o, req_valid_o, req_cmp_o;
  logic [1:0] req_level_o;
  logic signed [COEF_W-1:0] ge_o, be_o;

  int checks = 0, errors = 0, done_seen = 0;
  int g_lo1, g_lo0, g_hi1, g_hi0, p_base, p_slope, p_slope2, p_knee, n_val, npos, gap;
  int m_ge, m_be, m_init, m_bd;

  always #2.5 clk = ~clk;

  cal_gain_seq #(
    .MEAS_W(MEAS_W), .COEF_W(COEF_W), .MU_SHIFT(MU_SHIFT), .FIRST_G(FIRST_G),
    .G_UPD(G_UPD), .B_UPD(B_UPD), .N_CYC(N_CYC), .GE_INIT(GE_INIT),
    .GE_BACKOFF(GE_BACKOFF), .TMO_CYC(TMO_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .req_valid_o(req_valid_o), .req_level_o(req_level_o),
    .req_cmp_o(req_cmp_o), .meas_valid_i(meas_valid_i), .meas_i(meas_i),
    .ge_o(ge_o), .be_o(be_o)
  );

  always @(negedge clk) if (done_o) done_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : ((v < CMIN) ? CMIN : v);
  endfunction

  function automatic int gen(input int lvl, input int cmp);
    case (lvl)
      0: return cmp ? g_lo1 : g_lo0;
      1: return cmp ? g_hi1 : g_hi0;
      2: return p_base + ((npos < p_knee) ? p_slope * npos : p_slope2 * npos);
      default: return n_val;
    endcase
  endfunction

  // answer one request; starts and ends at a negedge
  task automatic serve(input int lvl, input int cmp, input bit poke, output int val);
    repeat (gap) @(negedge clk);
    chk(req_valid_o == 1'b1 && busy_o == 1'b1, "R8 request pending", int'(req_valid_o), 1);
    chk(int'(req_level_o) == lvl, (lvl < 2) ? "R2 level" : "R5 level", int'(req_level_o), lvl);
    chk(int'(req_cmp_o) == cmp, (lvl < 2) ? "R2 cmp" : "R4 cmp", int'(req_cmp_o), cmp);
    val = gen(lvl, cmp);
    if (lvl == 2) npos++;
    meas_i = MEAS_W'(val);
    meas_valid_i = 1'b1;
    start_i = poke;
    @(negedge clk);
    meas_valid_i = 1'b0;
    start_i = 1'b0;
    meas_i = MEAS_W'(12'h5a5);
  endtask

  task automatic begin_run();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    chk(timeout_o == 1'b0, "R10 timeout cleared by start", int'(timeout_o), 0);
    chk(int'(ge_o) == GE_INIT && int'(be_o) == 0, "R1 load on start", int'(ge_o), GE_INIT);
    m_ge = GE_INIT; m_init = GE_INIT; m_be = 0; m_bd = 0; npos = 0;
  endtask

  task automatic do_run(input int poke_at, input string tag);
    int a, b, c, d, p, n, nb, k, d0;
    bit restarted, first;
    d0 = done_seen;
    begin_run();
    k = 0;
    restarted = 1'b1;
    while (restarted) begin
      restarted = 1'b0;
      first = 1'b1;
      for (int cy = 0; cy <= N_CYC && !restarted; cy++) begin
        for (int g = 0; g < (first ? FIRST_G : G_UPD); g++) begin
          serve(0, 1, k == poke_at, a); k++;
          serve(0, 0, k == poke_at, b); k++;
          serve(1, 1, k == poke_at, c); k++;
          serve(1, 0, k == poke_at, d); k++;
          m_ge = sat(m_ge - (((a - b) + (c - d)) >>> (MU_SHIFT + 1)));
        end
        if (!first) begin
          for (int u = 0; u < B_UPD && !restarted; u++) begin
            serve(2, 0, k == poke_at, p); k++;
            serve(3, 0, k == poke_at, n); k++;
            nb = sat(m_be + ((p - n - m_bd) >>> MU_SHIFT));
            if ((m_be > 0 && nb < 0) || (m_be < 0 && nb > 0)) begin
              restarted = 1'b1;
              m_init = sat(m_init - GE_BACKOFF);
              m_ge = m_init;
              m_be = 0;
              // R7: restart values visible after the flipping update
              chk(int'(ge_o) == m_ge, "R7 ge restart", int'(ge_o), m_ge);
              chk(int'(be_o) == 0, "R7 be cleared", int'(be_o), 0);
            end else begin
              m_be = nb;
            end
          end
        end
        if (!restarted) begin
          serve(2, 0, k == poke_at, p); k++;
          serve(3, 0, k == poke_at, n); k++;
          m_bd = p - n;
        end
        first = 1'b0;
      end
    end
    chk(done_o == 1'b1 && busy_o == 1'b0, {tag, " R9 done at end"}, int'(done_o), 1);
    chk(int'(ge_o) == m_ge, {tag, " R3 final ge"}, int'(ge_o), m_ge);
    chk(int'(be_o) == m_be, {tag, " R4 final be"}, int'(be_o), m_be);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", int'(done_o), 0);
    chk(done_seen == d0 + 1, "R9 single done", done_seen, d0 + 1);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0 && req_valid_o == 1'b0, "R1 idle in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(done_o == 1'b0 && timeout_o == 1'b0, "R1 flags after reset", int'(done_o), 0);
    chk(int'(ge_o) == GE_INIT, "R1 ge reset", int'(ge_o), GE_INIT);
    chk(int'(be_o) == 0, "R1 be reset", int'(be_o), 0);
  endtask

  task automatic t_main();
    g_lo1 = 300; g_lo0 = 100; g_hi1 = -50; g_hi0 = -93;
    p_base = 500; p_slope = 6; p_slope2 = 6; p_knee = 1000; n_val = -500; gap = 0;
    do_run(7, "main+start ignored");
    chk(m_ge == 760 && m_be == 8, "R5 schedule totals", m_ge, 760);
  endtask

  task automatic t_floor();
    g_lo1 = 10; g_lo0 = 23; g_hi1 = 0; g_hi0 = 0;
    p_base = 500; p_slope = -5; p_slope2 = -5; p_knee = 1000; n_val = -500; gap = 3;
    do_run(-1, "negative floor");
    chk(int'(ge_o) == 1016, "R3 floor of negative sum", int'(ge_o), 1016);
  endtask

  task automatic t_sat();
    g_lo1 = -2000; g_lo0 = 2000; g_hi1 = -2000; g_hi0 = 2000;
    p_base = 500; p_slope = 0; p_slope2 = 0; p_knee = 1000; n_val = -500; gap = 0;
    do_run(-1, "saturation");
    chk(int'(ge_o) == CMAX, "R6 ge clamps high", int'(ge_o), CMAX);
  endtask

  task automatic t_restart();
    g_lo1 = 0; g_lo0 = 0; g_hi1 = 0; g_hi0 = 0;
    p_base = 500; p_slope = 8; p_slope2 = -40; p_knee = 4; n_val = -500; gap = 1;
    do_run(-1, "sign flip restart");
    chk(int'(ge_o) == GE_INIT - GE_BACKOFF, "R7 lowered start gain", int'(ge_o), GE_INIT - GE_BACKOFF);
    chk(be_o[COEF_W-1] == 1'b1, "R7 be negative after restart", int'(be_o), -1);
  endtask

  task automatic t_timeout();
    int v, d0;
    g_lo1 = 0; g_lo0 = 0; g_hi1 = 0; g_hi0 = 0; gap = 0;
    d0 = done_seen;
    begin_run();
    serve(0, 1, 1'b0, v);
    serve(0, 0, 1'b0, v);
    serve(1, 1, 1'b0, v);
    repeat (TMO_CYC - 1) @(negedge clk);
    chk(busy_o == 1'b1 && timeout_o == 1'b0, "R10 still waiting", int'(busy_o), 1);
    @(negedge clk);
    chk(busy_o == 1'b0, "R10 abort clears busy", int'(busy_o), 0);
    chk(timeout_o == 1'b1, "R10 timeout flag", int'(timeout_o), 1);
    chk(done_seen == d0, "R10 no done on abort", done_seen, d0);
  endtask

  task automatic t_idle_noise();
    logic signed [COEF_W-1:0] ge0, be0;
    ge0 = ge_o; be0 = be_o;
    for (int i = 0; i < 3; i++) begin
      meas_i = MEAS_W'(1500 - 900 * i);
      meas_valid_i = 1'b1;
      @(negedge clk);
    end
    meas_valid_i = 1'b0;
    @(negedge clk);
    chk(req_valid_o == 1'b0 && busy_o == 1'b0, "R8 no request while idle", int'(req_valid_o), 0);
    chk(ge_o == ge0, "R8 ge untouched by idle strobe", int'(ge_o), int'(ge0));
    chk(be_o == be0, "R8 be untouched by idle strobe", int'(be_o), int'(be0));
    chk(timeout_o == 1'b1, "R10 timeout sticky", int'(timeout_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_main();
    t_floor();
    t_sat();
    t_restart();
    t_timeout();
    t_idle_noise();
    t_main();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule